// File: doc/BRIEF.md
# Block-Partitioned Boolean Recurrence Solver

This block evaluates a first-order Boolean recurrence across a whole word in one combinational pass. Each result bit is set when its own generate bit is set, or when its propagate bit is set and the result bit just below it is set. The chain starts from a cleared bit below the lowest position. This is the carry structure of an adder, a priority scan and similar serial chains. The block never walks the word from one end to the other. It splits the word into blocks of H bits. Each block computes a local result that starts from zero, and each block also computes a running AND of its propagate bits. The top bits of the blocks form a shorter recurrence of the same kind, and the interior bits of each block are then corrected from the resolved top bit of the block below.

The shorter recurrence is solved by the same partitioned structure whenever it still has more than H entries. The split repeats until H entries or fewer remain, and that remainder is chained directly. There is no clock and no storage. Both the width N and the block size H must be powers of two, and H must be at least 2. Any other value stops elaboration.

Bit k of every vector carries recurrence index k+1. Bit 0 is the lowest position and bit N-1 is the highest.

Top module: `bool_recur_solver`

## Requirements
- R1: For all inputs, res_o[0] = gen_i[0], and for k ≥ 1, res_o[k] = gen_i[k] OR (prop_i[k] AND res_o[k-1]). Bit k holds index k+1.
- R2: prop_i[0] has no effect. Flipping it with all other inputs held leaves res_o unchanged.
- R3: With prop_i all ones, res_o[k] is the OR of gen_i[0] through gen_i[k].
- R4: With prop_i all zeros, res_o equals gen_i.
- R5: With gen_i all zeros, res_o is all zeros for any prop_i.
- R6: With prop_i all ones and one gen_i bit set at the top bit of a block (bit jH-1) or at the bottom bit of the next block (bit jH), every result bit at or above the set bit is one and every bit below it is zero.
- R7: The lowest H result bits depend only on the lowest H bits of gen_i and prop_i. Changing higher input bits does not move them.
- R8: When N/H exceeds H, the boundary recurrence is itself partitioned again, and the results still satisfy R1. For example, N=32 with H=2 recurses down through 16, 8, 4 and 2 entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gen_i | input | N | Generate term of each position; bit k is index k+1 |
| prop_i | input | N | Propagate term of each position; bit 0 is unused |
| res_o | output | N | Recurrence result at each position |

## Verification
The all-zero generate vector is applied first. It shows that no stray value enters the chain and that the propagate bits alone set nothing. All-ones propagate vectors with sparse generate bits expose a broken block product or a wrong boundary hand-off, because one set bit must fill the word above it. All-zeros propagate vectors confirm that no block passes anything upward when nothing propagates. Single generate bits at each side of every block edge separate errors in the boundary recurrence from errors in the interior correction. Random vectors, paired vectors that differ only in the lowest propagate bit or only above the first block, and a second instance with a two-bit block size cover the general case, the ignored input, block locality and the repeated partitioning.

// File: rtl/bool_recur_solver.sv
module bool_recur_solver #(
  parameter int unsigned N = 16,
  parameter int unsigned H = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  output logic [N-1:0] res_o
);
  localparam bit N_POW2 = (N != 0) && ((N & (N - 1)) == 0);
  localparam bit H_POW2 = (H != 0) && ((H & (H - 1)) == 0);
  localparam int unsigned NB = (N > H) ? N / H : 1;

  if (!N_POW2 || !H_POW2 || H < 2) begin : g_bad_param
    $error("bool_recur_solver: N and H must be powers of two and H at least 2");
  end

  if (N <= H) begin : g_direct
    logic [N-1:0] chain;
    wire unused_low_prop = prop_i[0];
    always_comb begin
      chain[0] = gen_i[0];
      for (int k = 1; k < N; k++)
        chain[k] = gen_i[k] | (prop_i[k] & chain[k-1]);
    end
    assign res_o = chain;
  end else begin : g_split
    logic [NB-1:0] bnd_gen;
    logic [NB-1:0] bnd_prop;
    logic [NB-1:0] bnd_res;

    for (genvar j = 0; j < NB; j++) begin : g_blk
      if (j == 0) begin : g_first
        logic [H-1:0] loc;
        wire unused_low_prop = prop_i[0];
        always_comb begin
          loc[0] = gen_i[0];
          for (int k = 1; k < H; k++)
            loc[k] = gen_i[k] | (prop_i[k] & loc[k-1]);
        end
        assign res_o[H-1:0] = loc;
        assign bnd_gen[0]   = loc[H-1];
        assign bnd_prop[0]  = 1'b0;
      end else begin : g_rest
        logic [H-1:0] loc;
        logic [H-1:0] prd;
        always_comb begin
          loc[0] = gen_i[j*H];
          prd[0] = prop_i[j*H];
          for (int k = 1; k < H; k++) begin
            loc[k] = gen_i[j*H+k] | (prop_i[j*H+k] & loc[k-1]);
            prd[k] = prop_i[j*H+k] & prd[k-1];
          end
        end
        assign bnd_gen[j]  = loc[H-1];
        assign bnd_prop[j] = prd[H-1];
        assign res_o[j*H +: H-1] = loc[H-2:0] | (prd[H-2:0] & {(H-1){bnd_res[j-1]}});
        assign res_o[j*H+H-1]    = bnd_res[j];
      end
    end

    bool_recur_solver #(.N(NB), .H(H)) u_bnd (
      .gen_i (bnd_gen),
      .prop_i(bnd_prop),
      .res_o (bnd_res)
    );
  end
endmodule

// File: rtl/bool_recur_solver_chk.sv
module bool_recur_solver_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned H = 4
) (
  input logic [N-1:0] gen_i,
  input logic [N-1:0] prop_i,
  input logic [N-1:0] res_o
);
  localparam int unsigned FB = (H < N) ? H : N;
  localparam logic [N-1:0] LOWM = {N{1'b1}} >> (N - FB);

  function automatic logic [N-1:0] walk(input logic [N-1:0] g, input logic [N-1:0] p);
    logic [N-1:0] r;
    logic carry;
    carry = 1'b0;
    for (int k = 0; k < N; k++) begin
      carry = g[k] | ((k != 0) & p[k] & carry);
      r[k] = carry;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] prefix_or(input logic [N-1:0] g);
    logic [N-1:0] r;
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      acc = acc | g[k];
      r[k] = acc;
    end
    return r;
  endfunction

  always_comb begin
    assert_serial_match_R1: assert (res_o == walk(gen_i, prop_i))
      else $error("R1: result %h differs from serial walk", res_o);
    if (&(prop_i | {{(N-1){1'b0}}, 1'b1}))
      assert_full_prop_R3: assert (res_o == prefix_or(gen_i))
        else $error("R3: result %h is not prefix OR", res_o);
    if ((prop_i >> 1) == '0)
      assert_no_prop_R4: assert (res_o == gen_i)
        else $error("R4: result %h differs from generate", res_o);
    if (gen_i == '0)
      assert_no_gen_R5: assert (res_o == '0)
        else $error("R5: result %h with no generate", res_o);
    assert_low_block_local_R7: assert ((res_o & LOWM) == (walk(gen_i & LOWM, prop_i & LOWM) & LOWM))
      else $error("R7: low block %h depends on upper inputs", res_o & LOWM);
  end
endmodule

bind bool_recur_solver bool_recur_solver_chk #(.N(N), .H(H)) chk_i (
  .gen_i (gen_i),
  .prop_i(prop_i),
  .res_o (res_o)
);

// File: tb/bool_recur_solver_tb_top.sv
module bool_recur_solver_tb_top;
  localparam int N  = 16;
  localparam int H  = 4;
  localparam int DN = 32;
  localparam int DH = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rst_n;

  logic [N-1:0]  gen, prop, res;
  logic [DN-1:0] dgen, dprop, dres;

  bool_recur_solver #(.N(N), .H(H)) dut_i (.gen_i(gen), .prop_i(prop), .res_o(res));
  bool_recur_solver #(.N(DN), .H(DH)) dut_deep_i (.gen_i(dgen), .prop_i(dprop), .res_o(dres));

  typedef struct {
    logic [N-1:0]  e;
    logic [DN-1:0] de;
    string         tag;
  } item_t;
  item_t q[$];

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] ref_chain(input logic [31:0] g, input logic [31:0] p, input int len);
    logic [31:0] r;
    logic carry;
    r = '0;
    carry = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (k == 0) carry = g[0];
      else carry = g[k] | (p[k] & carry);
      r[k] = carry;
    end
    return r;
  endfunction

  task automatic apply(input logic [N-1:0] g, input logic [N-1:0] p,
                       input logic [DN-1:0] dg, input logic [DN-1:0] dp, input string tag);
    item_t it;
    logic [31:0] t;
    @(posedge clk);
    gen = g; prop = p; dgen = dg; dprop = dp;
    t = ref_chain({16'b0, g}, {16'b0, p}, N);
    it.e = t[N-1:0];
    it.de = ref_chain(dg, dp, DN);
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    item_t it;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        applied++;
        if (res !== it.e || dres !== it.de) begin
          bad++;
          if (res !== it.e)
            $display("FAIL %s dut_i: res=%h expected %h", it.tag, res, it.e);
          if (dres !== it.de)
            $display("FAIL %s dut_deep_i: res=%h expected %h", it.tag, dres, it.de);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, actual no end expected end");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] g, p;
    logic [DN-1:0] dg, dp;
    rst_n = 1'b0;
    gen = '0; prop = '0; dgen = '0; dprop = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R5 reset state: all-zero inputs give all-zero results
    apply('0, '0, '0, '0, "R5 reset-state");
    for (int i = 0; i < 8; i++) begin
      p = N'($urandom); dp = $urandom;
      apply('0, p, '0, dp, "R5 no-generate");
    end

    // R3 full propagate: prefix OR
    for (int i = 0; i < 12; i++) begin
      g = N'($urandom) & N'($urandom) & N'($urandom); dg = $urandom & $urandom & $urandom;
      apply(g, '1, dg, '1, "R3 full-propagate");
    end

    // R4 no propagate: result equals generate
    for (int i = 0; i < 8; i++) begin
      g = N'($urandom); dg = $urandom;
      apply(g, '0, dg, '0, "R4 no-propagate");
    end

    // R6 single generate bit on both sides of each block edge
    for (int j = 1; j <= N / H; j++) begin
      apply(N'(1) << (j * H - 1), '1, DN'(1) << (j * H - 1), '1, "R6 block-top-bit");
      if (j < N / H)
        apply(N'(1) << (j * H), '1, DN'(1) << (j * H), '1, "R6 block-bottom-bit");
    end

    // R2 lowest propagate bit ignored: same vector with bit 0 flipped
    for (int i = 0; i < 6; i++) begin
      g = N'($urandom); p = N'($urandom); dg = $urandom; dp = $urandom;
      apply(g, p & ~N'(1), dg, dp & ~DN'(1), "R2 low-prop-clear");
      apply(g, p | N'(1), dg, dp | DN'(1), "R2 low-prop-set");
    end

    // R7 lowest block fixed while upper inputs vary
    g = N'($urandom); p = N'($urandom);
    for (int i = 0; i < 6; i++) begin
      apply((N'($urandom) & ~N'((1 << H) - 1)) | (g & N'((1 << H) - 1)),
            (N'($urandom) & ~N'((1 << H) - 1)) | (p & N'((1 << H) - 1)),
            $urandom, $urandom, "R7 low-block-locality");
    end

    // R8 deep recursion: single generate bit at every position, full propagate
    for (int k = 0; k < DN; k++)
      apply(N'(1) << (k % N), '1, DN'(1) << k, '1, "R8 deep-single-bit");

    // R1 general random vectors
    for (int i = 0; i < 300; i++) begin
      g = N'($urandom) & N'($urandom); p = N'($urandom) | N'($urandom);
      dg = $urandom & $urandom; dp = $urandom | $urandom;
      apply(g, p, dg, dp, "R1 random");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule